// File: doc/BRIEF.md
# Watchpoint Address Range Comparator

This block holds the configuration of a single data watchpoint. The configuration is a value register (a byte address) and a control word made of an enable bit, a two-bit access-type selector, a byte-select field and a power-of-two mask field. On the clock that follows a configuration write, the block turns this configuration into a registered inclusive byte range and a set of allowed access types. Each incoming data access is then compared against that range.

An access is given by its start address, a size code and a read/write flag. The block reports a hit when any byte the access covers lies inside the watched range and the access type is allowed. It also reports whether the hitting access was a write. Privilege filtering and any exception generation belong to the surrounding logic.

Top module: `wpr_top`

## Requirements
- R1: While the enable bit of the control word is 0, `hit_o` stays 0 for every access.
- R2: Access-type selector encoding: 0 is reserved and gives no hit, 1 matches reads only (`acc_write_i`=0), 2 matches writes only (`acc_write_i`=1), and 3 matches both.
- R3: Mask values 1 and 2 are reserved. With either value there is never a hit.
- R4: A mask value m of 3 or more watches 2^m bytes. The range starts at the value register with its low m bits cleared, and the byte-select field is ignored.
- R5: With mask 0 and bit 2 of the value register set, only byte-select bits 3:0 take part and bits 7:4 are treated as zero.
- R6: With mask 0, a byte-select value that is zero after the R5 reduction gives no hit.
- R7: With mask 0, the range starts at the value register plus the index of the lowest set byte-select bit. Its length is the number of consecutive ones that begin at that bit. Set bits above the first zero that follows the run are ignored.
- R8: Bits 1:0 of a value written to the value register are stored as zero.
- R9: Size code s (0..3) covers 1, 2, 4 or 8 bytes, from `acc_addr_i` to `acc_addr_i`+2^s-1. There is a hit when any of those bytes is inside the range.
- R10: After a clock edge that samples a configuration write, `hit_o` is 0 for one cycle. The new range applies from the cycle after that.
- R11: `wnr_o` is 1 exactly when `hit_o` is 1 and the access is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wvr_we_i | input | 1 | Write strobe for the value register |
| wvr_wdata_i | input | ADDR_W | Value register write data (byte address) |
| wcr_we_i | input | 1 | Write strobe for the control word |
| wcr_en_i | input | 1 | Control word: enable |
| wcr_lsc_i | input | 2 | Control word: access-type selector |
| wcr_bas_i | input | 8 | Control word: byte-select field |
| wcr_mask_i | input | 5 | Control word: power-of-two mask |
| acc_valid_i | input | 1 | Data access present |
| acc_addr_i | input | ADDR_W | Access start address |
| acc_size_i | input | 2 | Access size code (2^code bytes) |
| acc_write_i | input | 1 | Access is a write |
| hit_o | output | 1 | Access overlaps the watched range with an allowed type |
| wnr_o | output | 1 | Hit caused by a write |

## Verification
A configuration write and a matching access can occur in the same cycle, or in the cycle right after it. The bench provokes this by holding an access that matches the new range while it writes the configuration. It expects `hit_o` to be 0 in the cycle after the write edge and 1 in the cycle after that. The block's own assertion states the same rule, so any hit that arrives one cycle early is caught.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  localparam int BAS_W  = 8;
  localparam int MASK_W = 5;
  localparam int LSC_W  = 2;

  typedef struct packed {
    logic              en;
    logic [LSC_W-1:0]  lsc;
    logic [BAS_W-1:0]  bas;
    logic [MASK_W-1:0] mask;
  } wcr_t;
endpackage

// File: rtl/wpr_bas_decode.sv
module wpr_bas_decode #(
  parameter int BAS_W = 8,
  localparam int IDX_W = $clog2(BAS_W),
  localparam int LEN_W = $clog2(BAS_W) + 1
) (
  input  logic [BAS_W-1:0] bas_i,
  output logic [IDX_W-1:0] start_o,
  output logic [LEN_W-1:0] len_o
);
  logic seen, stop;

  // first run of ones only; later ones are dropped
  always_comb begin
    start_o = '0;
    len_o   = '0;
    seen    = 1'b0;
    stop    = 1'b0;
    for (int i = 0; i < BAS_W; i++) begin
      if (!seen && bas_i[i]) begin
        seen    = 1'b1;
        start_o = IDX_W'(i);
      end
      if (seen && !stop) begin
        if (bas_i[i]) len_o = len_o + LEN_W'(1);
        else          stop  = 1'b1;
      end
    end
  end

  always_comb begin
    if (len_o != '0) a_r7_start_is_set: assert (bas_i[start_o]);
    a_r6_zero_len_iff_empty: assert ((len_o == '0) == (bas_i == '0));
  end
endmodule

// File: rtl/wpr_range_calc.sv
module wpr_range_calc
  import wpr_pkg::*;
#(
  parameter int ADDR_W = 48,
  localparam int IDX_W = $clog2(BAS_W),
  localparam int LEN_W = $clog2(BAS_W) + 1,
  localparam int HALF  = BAS_W / 2
) (
  input  logic [ADDR_W-1:0] wvr_i,
  input  wcr_t              wcr_i,
  output logic              valid_o,
  output logic [ADDR_W:0]   lo_o,
  output logic [ADDR_W:0]   hi_o
);
  typedef logic [ADDR_W:0] ext_t;

  logic [BAS_W-1:0] bas_eff;
  logic [IDX_W-1:0] start;
  logic [LEN_W-1:0] len;
  logic             mask_rsv;
  ext_t             span, base;

  // 4-aligned value: upper half of byte select ignored
  assign bas_eff  = wvr_i[2] ? {{(BAS_W-HALF){1'b0}}, wcr_i.bas[HALF-1:0]} : wcr_i.bas;
  assign mask_rsv = (wcr_i.mask == MASK_W'(1)) || (wcr_i.mask == MASK_W'(2));
  assign span     = ext_t'(1) << wcr_i.mask;
  assign base     = {1'b0, wvr_i};

  wpr_bas_decode #(.BAS_W(BAS_W)) u_bas (
    .bas_i   (bas_eff),
    .start_o (start),
    .len_o   (len)
  );

  always_comb begin
    if (wcr_i.mask != '0) begin
      lo_o = base & ~(span - ext_t'(1));
      hi_o = lo_o + span - ext_t'(1);
    end else begin
      lo_o = base + ext_t'(start);
      hi_o = lo_o + ext_t'(len) - ext_t'(1);
    end
  end

  assign valid_o = wcr_i.en && (wcr_i.lsc != '0) && !mask_rsv &&
                   ((wcr_i.mask != '0) || (bas_eff != '0));
endmodule

// File: rtl/wpr_overlap.sv
module wpr_overlap #(
  parameter int ADDR_W = 48,
  parameter int SIZE_W = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [ADDR_W:0]   lo_i,
  input  logic [ADDR_W:0]   hi_i,
  output logic              ovl_o
);
  typedef logic [ADDR_W:0] ext_t;

  ext_t acc_lo, acc_hi;

  assign acc_lo = {1'b0, addr_i};
  assign acc_hi = acc_lo + (ext_t'(1) << size_i) - ext_t'(1);
  assign ovl_o  = (acc_lo <= hi_i) && (acc_hi >= lo_i);
endmodule

// File: rtl/wpr_top.sv
module wpr_top
  import wpr_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int SIZE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wvr_we_i,
  input  logic [ADDR_W-1:0] wvr_wdata_i,
  input  logic              wcr_we_i,
  input  logic              wcr_en_i,
  input  logic [LSC_W-1:0]  wcr_lsc_i,
  input  logic [BAS_W-1:0]  wcr_bas_i,
  input  logic [MASK_W-1:0] wcr_mask_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [SIZE_W-1:0] acc_size_i,
  input  logic              acc_write_i,
  output logic              hit_o,
  output logic              wnr_o
);
  logic [ADDR_W-1:0] wvr_q;
  wcr_t              wcr_q;
  logic              upd_q;
  logic              rng_vld_q, calc_vld;
  logic [LSC_W-1:0]  rng_lsc_q;
  logic [ADDR_W:0]   rng_lo_q, rng_hi_q, calc_lo, calc_hi;
  logic              ovl, type_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wvr_q <= '0;
      wcr_q <= '0;
      upd_q <= 1'b0;
    end else begin
      if (wvr_we_i) wvr_q <= {wvr_wdata_i[ADDR_W-1:2], 2'b00};
      if (wcr_we_i) wcr_q <= '{en: wcr_en_i, lsc: wcr_lsc_i, bas: wcr_bas_i, mask: wcr_mask_i};
      upd_q <= wvr_we_i || wcr_we_i;
    end
  end

  wpr_range_calc #(.ADDR_W(ADDR_W)) u_calc (
    .wvr_i   (wvr_q),
    .wcr_i   (wcr_q),
    .valid_o (calc_vld),
    .lo_o    (calc_lo),
    .hi_o    (calc_hi)
  );

  // range registered one clock after the config registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rng_vld_q <= 1'b0;
      rng_lsc_q <= '0;
      rng_lo_q  <= '0;
      rng_hi_q  <= '0;
    end else if (upd_q) begin
      rng_vld_q <= calc_vld;
      rng_lsc_q <= wcr_q.lsc;
      rng_lo_q  <= calc_lo;
      rng_hi_q  <= calc_hi;
    end
  end

  wpr_overlap #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ovl (
    .addr_i (acc_addr_i),
    .size_i (acc_size_i),
    .lo_i   (rng_lo_q),
    .hi_i   (rng_hi_q),
    .ovl_o  (ovl)
  );

  assign type_ok = acc_write_i ? rng_lsc_q[1] : rng_lsc_q[0];
  assign hit_o   = acc_valid_i && rng_vld_q && !upd_q && type_ok && ovl;
  assign wnr_o   = hit_o && acc_write_i;

  a_r1_disabled_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wcr_q.en && !upd_q) |-> !hit_o);
  a_r2_read_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !acc_write_i) |-> wcr_q.lsc[0]);
  a_r2_write_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && acc_write_i) |-> wcr_q.lsc[1]);
  a_r3_mask_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> !((wcr_q.mask == MASK_W'(1)) || (wcr_q.mask == MASK_W'(2))));
  a_r10_update_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wvr_we_i || wcr_we_i) |=> !hit_o);
endmodule

// File: tb/sim_wpr_top.sv
module sim_wpr_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 48;

  typedef struct packed {
    logic [47:0] wvr;
    logic        en;
    logic [1:0]  lsc;
    logic [7:0]  bas;
    logic [4:0]  mask;
    logic [47:0] addr;
    logic [1:0]  size;
    logic        wr;
    logic        hit;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{48'h1000, 1'b1, 2'd3, 8'h01, 5'd0, 48'h1000, 2'd0, 1'b0, 1'b1, 8'd7}, // R7 single byte
    '{48'h1000, 1'b1, 2'd3, 8'h01, 5'd0, 48'h1001, 2'd0, 1'b0, 1'b0, 8'd7},
    '{48'h1000, 1'b0, 2'd3, 8'h01, 5'd0, 48'h1000, 2'd0, 1'b0, 1'b0, 8'd1}, // R1
    '{48'h1000, 1'b1, 2'd0, 8'h01, 5'd0, 48'h1000, 2'd0, 1'b0, 1'b0, 8'd2}, // R2 reserved
    '{48'h1000, 1'b1, 2'd1, 8'h01, 5'd0, 48'h1000, 2'd0, 1'b1, 1'b0, 8'd2},
    '{48'h1000, 1'b1, 2'd1, 8'h01, 5'd0, 48'h1000, 2'd0, 1'b0, 1'b1, 8'd2},
    '{48'h1000, 1'b1, 2'd2, 8'h01, 5'd0, 48'h1000, 2'd0, 1'b1, 1'b1, 8'd2},
    '{48'h1000, 1'b1, 2'd2, 8'h01, 5'd0, 48'h1000, 2'd0, 1'b0, 1'b0, 8'd2},
    '{48'h1000, 1'b1, 2'd3, 8'h0C, 5'd0, 48'h1001, 2'd0, 1'b0, 1'b0, 8'd7}, // R7 offset start
    '{48'h1000, 1'b1, 2'd3, 8'h0C, 5'd0, 48'h1002, 2'd0, 1'b1, 1'b1, 8'd7},
    '{48'h1000, 1'b1, 2'd3, 8'h0C, 5'd0, 48'h1003, 2'd0, 1'b0, 1'b1, 8'd7},
    '{48'h1000, 1'b1, 2'd3, 8'h0C, 5'd0, 48'h1004, 2'd0, 1'b0, 1'b0, 8'd7},
    '{48'h1000, 1'b1, 2'd3, 8'h0C, 5'd0, 48'h1000, 2'd1, 1'b0, 1'b0, 8'd9}, // R9 sizes
    '{48'h1000, 1'b1, 2'd3, 8'h0C, 5'd0, 48'h1000, 2'd2, 1'b1, 1'b1, 8'd9},
    '{48'h1000, 1'b1, 2'd3, 8'h8D, 5'd0, 48'h1002, 2'd0, 1'b0, 1'b0, 8'd7}, // R7 later ones
    '{48'h1000, 1'b1, 2'd3, 8'h8D, 5'd0, 48'h1007, 2'd0, 1'b0, 1'b0, 8'd7},
    '{48'h1000, 1'b1, 2'd3, 8'h8D, 5'd0, 48'h1000, 2'd0, 1'b0, 1'b1, 8'd7},
    '{48'h1004, 1'b1, 2'd3, 8'hF0, 5'd0, 48'h1004, 2'd0, 1'b0, 1'b0, 8'd5}, // R5
    '{48'h1004, 1'b1, 2'd3, 8'h12, 5'd0, 48'h1005, 2'd0, 1'b0, 1'b1, 8'd5},
    '{48'h1004, 1'b1, 2'd3, 8'h12, 5'd0, 48'h1008, 2'd0, 1'b0, 1'b0, 8'd5},
    '{48'h1000, 1'b1, 2'd3, 8'h00, 5'd0, 48'h1000, 2'd0, 1'b0, 1'b0, 8'd6}, // R6
    '{48'h1000, 1'b1, 2'd3, 8'hFF, 5'd1, 48'h1000, 2'd0, 1'b0, 1'b0, 8'd3}, // R3
    '{48'h1000, 1'b1, 2'd3, 8'hFF, 5'd2, 48'h1000, 2'd0, 1'b0, 1'b0, 8'd3},
    '{48'h1005, 1'b1, 2'd3, 8'h00, 5'd3, 48'h1000, 2'd0, 1'b0, 1'b1, 8'd4}, // R4
    '{48'h1005, 1'b1, 2'd3, 8'h00, 5'd3, 48'h1007, 2'd0, 1'b1, 1'b1, 8'd4},
    '{48'h1005, 1'b1, 2'd3, 8'h00, 5'd3, 48'h1008, 2'd0, 1'b0, 1'b0, 8'd4},
    '{48'h1005, 1'b1, 2'd3, 8'h00, 5'd3, 48'h0FFF, 2'd0, 1'b0, 1'b0, 8'd4},
    '{48'h1005, 1'b1, 2'd3, 8'h00, 5'd3, 48'h0FFF, 2'd1, 1'b0, 1'b1, 8'd9},
    '{48'h12345, 1'b1, 2'd3, 8'h00, 5'd8, 48'h12300, 2'd0, 1'b0, 1'b1, 8'd4},
    '{48'h12345, 1'b1, 2'd3, 8'h00, 5'd8, 48'h123FF, 2'd0, 1'b0, 1'b1, 8'd4},
    '{48'h12345, 1'b1, 2'd3, 8'h00, 5'd8, 48'h12400, 2'd0, 1'b0, 1'b0, 8'd4},
    '{48'h2003, 1'b1, 2'd3, 8'h01, 5'd0, 48'h2000, 2'd0, 1'b0, 1'b1, 8'd8}, // R8
    '{48'h2003, 1'b1, 2'd3, 8'h01, 5'd0, 48'h2003, 2'd0, 1'b0, 1'b0, 8'd8},
    '{48'h1000, 1'b1, 2'd3, 8'h01, 5'd0, 48'h0FF9, 2'd3, 1'b1, 1'b1, 8'd9}  // R9 8-byte span
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wvr_we = 1'b0, wcr_we = 1'b0;
  logic [AW-1:0] wvr_wdata = '0;
  logic          wcr_en = 1'b0;
  logic [1:0]    wcr_lsc = '0;
  logic [7:0]    wcr_bas = '0;
  logic [4:0]    wcr_mask = '0;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0]    acc_size = '0;
  logic          acc_write = 1'b0;
  logic          hit, wnr;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wpr_top #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .wvr_we_i(wvr_we), .wvr_wdata_i(wvr_wdata),
    .wcr_we_i(wcr_we), .wcr_en_i(wcr_en), .wcr_lsc_i(wcr_lsc),
    .wcr_bas_i(wcr_bas), .wcr_mask_i(wcr_mask),
    .acc_valid_i(acc_valid), .acc_addr_i(acc_addr), .acc_size_i(acc_size),
    .acc_write_i(acc_write), .hit_o(hit), .wnr_o(wnr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drives a write; returns in the cycle after the write edge
  task automatic write_cfg(input vec_t v);
    @(negedge clk);
    wvr_we = 1'b1; wcr_we = 1'b1;
    wvr_wdata = v.wvr; wcr_en = v.en; wcr_lsc = v.lsc; wcr_bas = v.bas; wcr_mask = v.mask;
    @(negedge clk);
    wvr_we = 1'b0; wcr_we = 1'b0;
  endtask

  task automatic set_acc(input vec_t v);
    acc_valid = 1'b1; acc_addr = v.addr; acc_size = v.size; acc_write = v.wr;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t d;
    repeat (3) @(negedge clk);
    acc_valid = 1'b1; acc_addr = '0; acc_size = 2'd3; acc_write = 1'b1;
    #1;
    check("R1 reset hit", hit, 0);
    check("R11 reset wnr", wnr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", hit, 0);

    for (int i = 0; i < NV; i++) begin
      write_cfg(VEC[i]);
      @(negedge clk);
      set_acc(VEC[i]);
      #1;
      check($sformatf("R%0d vec %0d hit", VEC[i].req, i), hit, VEC[i].hit);
      check($sformatf("R11 vec %0d wnr", i), wnr, VEC[i].hit & VEC[i].wr);
    end

    // R10: access held matching while the config is written
    d = '{48'h3000, 1'b1, 2'd3, 8'h0F, 5'd0, 48'h3002, 2'd0, 1'b1, 1'b1, 8'd10};
    @(negedge clk);
    set_acc(d);
    write_cfg(d);
    #1;
    check("R10 quiet cycle", hit, 0);
    @(negedge clk); #1;
    check("R10 new range live", hit, 1);
    check("R11 write hit", wnr, 1);

    // R10: value-only write moves the range; old range dead after update
    @(negedge clk);
    wvr_we = 1'b1; wvr_wdata = 48'h4000;
    @(negedge clk);
    wvr_we = 1'b0; #1;
    check("R10 value write quiet", hit, 0);
    @(negedge clk); #1;
    check("R10 old range gone", hit, 0);
    acc_addr = 48'h4003; #1;
    check("R10 moved range", hit, 1);

    // R8: write value with low bits set, byte 0 only, mask 0
    d = '{48'h5002, 1'b1, 2'd1, 8'h01, 5'd0, 48'h5000, 2'd0, 1'b0, 1'b1, 8'd8};
    write_cfg(d);
    @(negedge clk);
    set_acc(d); #1;
    check("R8 low bits cleared", hit, 1);
    check("R11 read hit wnr", wnr, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule